// File: doc/BRIEF.md
# I2C Serial-Memory Slave

This block is an I2C target that looks to a bus master like a small serial EEPROM. The storage behind it is ordinary on-chip RAM. It samples the bus lines through synchronizers and finds start, repeated-start and stop conditions. It compares a 7-bit device address and takes in a byte address. It then moves data bytes to or from the RAM through a request/acknowledge memory port. The SDA line is only ever pulled low.

A write transfer loads a byte pointer and stores the bytes that follow. The pointer wraps inside a page whose size is chosen at run time. A read transfer returns bytes starting at the pointer. The pointer steps over the whole address space and rolls from the top back to zero. A write that carries no data only moves the pointer. This gives random reads, either with a repeated start or with a stop followed by a fresh read.

After every write transfer that stored data, the block locks itself busy and ignores its address until software releases it. A two-bit event register records finished writes and finished reads. It drives an interrupt line when the interrupt is enabled.

Top module: `i2cm_slave`

## Requirements
- R1: A start or repeated start begins a new address phase from any state. The block acknowledges only the 7-bit address DEV_ADDR. Any other address is not acknowledged, and the bus is then ignored until the next start.
- R2: In a transfer with R/W low, the first byte after the address is acknowledged and becomes the current address. Each later byte is acknowledged and stored with one memory write request (mem_we_o=1) at the current address. The request stays raised, with a stable address, until mem_ack_i.
- R3: After each stored byte, the pointer advances within a page of 8, 16, 32 or 64 bytes for cfg_page_len codes 0, 1, 2 and 3. The bits above the page are kept and the low bits wrap to the page start.
- R4: A transfer with R/W high and no address phase returns the byte at the current address. The current address always equals the last address read or written plus one (cur_addr_o).
- R5: A write that carries only the byte address stores nothing and does not set busy. The following read returns the byte at that address, whether the read follows a repeated start or a stop and a new start.
- R6: While the master acknowledges, the read continues with the next address, rolling from 255 to 0. After a master NACK the block leaves SDA released until the next start.
- R7: A stop or repeated start that ends a write transfer which stored at least one byte sets busy_o. While busy_o is high, the block does not acknowledge its own address. Only a busy_clr pulse lowers busy_o.
- R8: status_o bit 0 is set when a write transfer that stored data ends. Bit 1 is set when a read transfer that sent data ends. A status_rd pulse clears both bits, and a new event in the same cycle wins over the clear.
- R9: irq_o is a register that is high one cycle after cfg_irq_en and some status_o bit are both high. It is low whenever cfg_irq_en was low in the previous cycle.
- R10: byte_cnt_o counts the data bytes moved in the current or most recent transfer. It restarts from zero on each acknowledged address.
- R11: sda_oe (1 = pull SDA low) changes only while the synchronized SCL is low. After reset it is 0, busy_o is 0, status_o is 0, irq_o is 0 and cur_addr_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | I2C clock line as seen on the pin |
| sda_i | input | 1 | I2C data line as seen on the pin |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cfg_page_len | input | 2 | Page size code for writes |
| cfg_irq_en | input | 1 | Interrupt enable |
| busy_clr | input | 1 | Pulse that releases the busy lock |
| status_rd | input | 1 | Pulse that marks the event register as read and clears it |
| busy_o | output | 1 | Busy lock |
| status_o | output | 2 | Events: bit 0 write done, bit 1 read done |
| cur_addr_o | output | ADDR_W | Current address pointer |
| byte_cnt_o | output | CNT_W | Data bytes in the current or last transfer |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge |

## Verification
The bench aims page writes at the last bytes of a page for several page sizes. A design that carried into the next page, or wrapped to address zero, would leave the wrong RAM bytes changed. Reads are started just below the top of memory, so the rollover to zero is exercised, and a master NACK is followed by an extra byte clocked out. A block that kept driving after the NACK would show non-FF data. Random reads are made with a repeated start and also with a stop. These runs show whether an address-only write wrongly locks the block busy. The bench also sends the device address during the lock and sends a foreign address, and neither may be acknowledged or store anything.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RACK,
    ST_RNEXT,
    ST_SKIP
  } st_e;

  typedef enum logic [1:0] {
    PTR_HOLD,
    PTR_LOAD,
    PTR_WRAP,
    PTR_ROLL
  } ptr_op_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_bit
      logic [STAGES-1:0] chain;
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d[gi]};
      end
      assign q[gi] = chain[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/i2cm_cond.sv
module i2cm_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic start,
  output logic stop,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign start    = scl_q & scl & sda_q & ~sda;
  assign stop     = scl_q & scl & ~sda_q & sda;
  assign scl_rise = ~scl_q & scl;
  assign scl_fall = scl_q & ~scl;
endmodule

// File: rtl/i2cm_ptr.sv
module i2cm_ptr
  import i2cm_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int PAGE_MIN_LOG2 = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ptr_op_e           op,
  input  logic [ADDR_W-1:0] ld_val,
  input  logic [1:0]        page_sel,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] mask, wrap_nxt, roll_nxt;

  always_comb begin
    mask     = ADDR_W'((64'd1 << (PAGE_MIN_LOG2 + int'(page_sel))) - 64'd1);
    roll_nxt = ptr_o + 1'b1;
    wrap_nxt = (ptr_o & ~mask) | (roll_nxt & mask);
  end

  always_ff @(posedge clk) begin
    if (rst) ptr_o <= '0;
    else begin
      case (op)
        PTR_LOAD: ptr_o <= ld_val;
        PTR_WRAP: ptr_o <= wrap_nxt;
        PTR_ROLL: ptr_o <= roll_nxt;
        default:  ptr_o <= ptr_o;
      endcase
    end
  end
endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int          ADDR_W        = 8,
  parameter int          CNT_W         = 8,
  parameter int          SYNC_STAGES   = 2,
  parameter int          PAGE_MIN_LOG2 = 3,
  parameter logic [6:0]  DEV_ADDR      = 7'h50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [1:0]        cfg_page_len,
  input  logic              cfg_irq_en,
  input  logic              busy_clr,
  input  logic              status_rd,
  output logic              busy_o,
  output logic [1:0]        status_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              irq_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [BYTE_W-1:0] mem_wdata_o,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  input  logic              mem_ack_i
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  logic              scl_s, sda_s;
  logic              start, stop, scl_rise, scl_fall;
  st_e               st;
  logic [3:0]        bitcnt;
  logic [BYTE_W-1:0] shreg, txreg, rdbuf;
  logic              rw, wr_any, rd_any, dev_hit, byte_end;
  logic [1:0]        evt_set;
  ptr_op_e           ptr_op;

  i2cm_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q({scl_s, sda_s})
  );

  i2cm_cond u_cond (
    .clk(clk), .rst(rst), .scl(scl_s), .sda(sda_s),
    .start(start), .stop(stop), .scl_rise(scl_rise), .scl_fall(scl_fall)
  );

  i2cm_ptr #(.ADDR_W(ADDR_W), .PAGE_MIN_LOG2(PAGE_MIN_LOG2)) u_ptr (
    .clk(clk), .rst(rst), .op(ptr_op), .ld_val(ADDR_W'(shreg)),
    .page_sel(cfg_page_len), .ptr_o(cur_addr_o)
  );

  assign dev_hit  = (shreg[7:1] == DEV_ADDR) && !busy_o;
  assign byte_end = scl_fall && (bitcnt == LAST_BIT);
  assign evt_set  = {2{start | stop}} & {rd_any, wr_any};

  // pointer actions, taken in the same cycle as the matching FSM step
  always_comb begin
    ptr_op = PTR_HOLD;
    if (!start && !stop) begin
      case (st)
        ST_DEV:  if (byte_end && dev_hit && shreg[0]) ptr_op = PTR_ROLL;
        ST_WADR: if (byte_end) ptr_op = PTR_LOAD;
        ST_WDAT: if (byte_end) ptr_op = PTR_WRAP;
        ST_RACK: if (scl_rise && !sda_s) ptr_op = PTR_ROLL;
        default: ptr_op = PTR_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      txreg       <= '0;
      rdbuf       <= '0;
      rw          <= 1'b0;
      wr_any      <= 1'b0;
      rd_any      <= 1'b0;
      sda_oe      <= 1'b0;
      byte_cnt_o  <= '0;
      mem_req_o   <= 1'b0;
      mem_we_o    <= 1'b0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
    end else begin
      if (mem_req_o && mem_ack_i) begin
        mem_req_o <= 1'b0;
        if (!mem_we_o) rdbuf <= mem_rdata_i;
      end

      if (start || stop) begin
        st     <= start ? ST_DEV : ST_IDLE;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        wr_any <= 1'b0;
        rd_any <= 1'b0;
      end else begin
        case (st)
          ST_DEV, ST_WADR, ST_WDAT: begin
            if (scl_rise) begin
              shreg  <= {shreg[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (byte_end) begin
              if (st == ST_DEV) begin
                if (dev_hit) begin
                  sda_oe     <= 1'b1;
                  rw         <= shreg[0];
                  byte_cnt_o <= '0;
                  st         <= ST_DEV_ACK;
                  if (shreg[0]) begin
                    mem_req_o  <= 1'b1;
                    mem_we_o   <= 1'b0;
                    mem_addr_o <= cur_addr_o;
                  end
                end else begin
                  st <= ST_SKIP;
                end
              end else if (st == ST_WADR) begin
                sda_oe <= 1'b1;
                st     <= ST_WADR_ACK;
              end else begin
                mem_req_o   <= 1'b1;
                mem_we_o    <= 1'b1;
                mem_addr_o  <= cur_addr_o;
                mem_wdata_o <= shreg;
                wr_any      <= 1'b1;
                byte_cnt_o  <= byte_cnt_o + 1'b1;
                sda_oe      <= 1'b1;
                st          <= ST_WDAT_ACK;
              end
            end
          end
          ST_DEV_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                txreg      <= rdbuf;
                sda_oe     <= ~rdbuf[BYTE_W-1];
                rd_any     <= 1'b1;
                byte_cnt_o <= byte_cnt_o + 1'b1;
                st         <= ST_RDAT;
              end else begin
                sda_oe <= 1'b0;
                st     <= ST_WADR;
              end
            end
          end
          ST_WADR_ACK, ST_WDAT_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WDAT;
            end
          end
          ST_RDAT: begin
            if (scl_rise) bitcnt <= bitcnt + 1'b1;
            else if (scl_fall) begin
              if (bitcnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                txreg  <= {txreg[BYTE_W-2:0], 1'b0};
                sda_oe <= ~txreg[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (!sda_s) begin
                mem_req_o  <= 1'b1;
                mem_we_o   <= 1'b0;
                mem_addr_o <= cur_addr_o;
                st         <= ST_RNEXT;
              end else begin
                st <= ST_SKIP;
              end
            end
          end
          ST_RNEXT: begin
            if (scl_fall) begin
              bitcnt     <= '0;
              txreg      <= rdbuf;
              sda_oe     <= ~rdbuf[BYTE_W-1];
              byte_cnt_o <= byte_cnt_o + 1'b1;
              st         <= ST_RDAT;
            end
          end
          default: st <= st;
        endcase
      end
    end
  end

  // busy lock, event flags and interrupt
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_o   <= 1'b0;
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      busy_o   <= (busy_o & ~busy_clr) | evt_set[0];
      status_o <= (status_rd ? 2'b00 : status_o) | evt_set;
      irq_o    <= cfg_irq_en & (|status_o);
    end
  end
endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              scl_s,
  input logic              sda_oe,
  input logic              busy,
  input logic              busy_clr,
  input logic [1:0]        status,
  input logic              status_rd,
  input logic [1:0]        evt_set,
  input logic              irq,
  input logic              irq_en,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);
  // R11
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_s);

  // R7
  busy_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(busy_clr));

  // R7
  busy_event_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> status[0]);

  // R8
  status_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && evt_set == 2'b00) |=> (status == 2'b00));

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq);

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
endmodule

bind i2cm_slave i2cm_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe), .busy(busy_o),
  .busy_clr(busy_clr), .status(status_o), .status_rd(status_rd),
  .evt_set(evt_set), .irq(irq_o), .irq_en(cfg_irq_en), .mem_req(mem_req_o),
  .mem_ack(mem_ack_i), .mem_we(mem_we_o), .mem_addr(mem_addr_o)
);

// File: tb/i2cm_slave_bench.sv
module i2cm_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 16;
  localparam logic [6:0] DEV = 7'h50;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       sda_oe, sda_line;
  logic [1:0] cfg_page_len = 2'd0;
  logic       cfg_irq_en = 1'b0, busy_clr = 1'b0, status_rd = 1'b0;
  logic       busy, irq, mem_req, mem_we;
  logic       mem_ack = 1'b0;
  logic [1:0] status;
  logic [7:0] cur_addr, byte_cnt, mem_addr, mem_wdata, mem_rdata;

  logic [7:0] ram     [256];
  logic [7:0] exp_ram [256];
  logic [7:0] wbuf    [8];
  logic [7:0] rbuf    [8];
  logic [7:0] exp_ptr;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2cm_slave u_i2cm_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .cfg_page_len(cfg_page_len), .cfg_irq_en(cfg_irq_en), .busy_clr(busy_clr),
    .status_rd(status_rd), .busy_o(busy), .status_o(status),
    .cur_addr_o(cur_addr), .byte_cnt_o(byte_cnt), .irq_o(irq),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack)
  );

  // RAM model
  assign mem_rdata = ram[mem_addr];
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) ram[i] <= 8'(i) ^ 8'hA5;
      mem_ack <= 1'b0;
    end else begin
      if (mem_req && !mem_ack && mem_we) ram[mem_addr] <= mem_wdata;
      mem_ack <= mem_req && !mem_ack;
    end
  end

  function automatic logic [7:0] page_addr(input logic [7:0] a, input logic [1:0] pl, input int k);
    logic [7:0] m;
    m = 8'((8 << pl) - 1);
    return (a & ~m) | (8'(int'(a) + k) & m);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic w(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    sda_m = 1'b0; w(H); scl_m = 1'b0;
  endtask

  task automatic i2c_restart;
    w(H/2); sda_m = 1'b1; w(H/2); scl_m = 1'b1; w(H); sda_m = 1'b0; w(H); scl_m = 1'b0;
  endtask

  task automatic i2c_stop;
    w(H/2); sda_m = 1'b0; w(H/2); scl_m = 1'b1; w(H); sda_m = 1'b1; w(H);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      w(H/2); sda_m = b[i]; w(H/2); scl_m = 1'b1; w(H); scl_m = 1'b0;
    end
    w(H/2); sda_m = 1'b1; w(H/2); scl_m = 1'b1; w(H/2);
    ack = ~sda_line; w(H/2); scl_m = 1'b0;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic give_ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; w(H); scl_m = 1'b1; w(H/2); b[i] = sda_line; w(H/2); scl_m = 1'b0;
    end
    w(H/2); sda_m = ~give_ack; w(H/2); scl_m = 1'b1; w(H); scl_m = 1'b0;
    w(H/2); sda_m = 1'b1; w(H/2);
  endtask

  task automatic sw_release;
    busy_clr = 1'b1; status_rd = 1'b1; w(1); busy_clr = 1'b0; status_rd = 1'b0; w(2);
  endtask

  // write n bytes from wbuf starting at a; updates the expected model
  task automatic do_write(input logic [7:0] a, input int n, output logic all_ack);
    logic ak;
    all_ack = 1'b1;
    i2c_start;
    send_byte({DEV, 1'b0}, ak); all_ack &= ak;
    send_byte(a, ak); all_ack &= ak;
    for (int k = 0; k < n; k++) begin
      send_byte(wbuf[k], ak); all_ack &= ak;
      exp_ram[page_addr(a, cfg_page_len, k)] = wbuf[k];
    end
    i2c_stop;
    exp_ptr = (n == 0) ? a : page_addr(a, cfg_page_len, n);
  endtask

  // address-only write, repeated start, read n bytes (last one NACKed)
  task automatic do_rand_read(input logic [7:0] a, input int n);
    logic ak;
    i2c_start;
    send_byte({DEV, 1'b0}, ak);
    send_byte(a, ak);
    i2c_restart;
    send_byte({DEV, 1'b1}, ak);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    i2c_stop;
    exp_ptr = 8'(int'(a) + n);
  endtask

  initial begin
    logic ak, aa;
    logic [7:0] b;
    logic [1:0] pl;
    logic [7:0] a;
    int n;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 256; i++) exp_ram[i] = 8'(i) ^ 8'hA5;
    exp_ptr = 8'h00;
    w(5); rst = 1'b0; w(3);

    // R11 reset state
    chk("R11 sda_oe reset", sda_oe, 0);
    chk("R11 busy reset", busy, 0);
    chk("R11 status reset", status, 0);
    chk("R11 irq reset", irq, 0);
    chk("R11 ptr reset", cur_addr, 0);

    // R2 byte write
    wbuf[0] = 8'h3C;
    do_write(8'h12, 1, aa);
    chk("R1 R2 write acks", aa, 1);
    chk("R2 byte stored", ram[8'h12], 8'h3C);
    chk("R4 ptr after write", cur_addr, 8'h13);
    chk("R10 byte count", byte_cnt, 1);
    chk("R7 busy after write", busy, 1);
    chk("R8 write event", status, 2'b01);
    chk("R9 irq gated off", irq, 0);
    cfg_irq_en = 1'b1; w(3);
    chk("R9 irq enabled", irq, 1);

    // R7 address ignored while locked
    i2c_start; send_byte({DEV, 1'b0}, ak); send_byte(8'h12, ak); send_byte(8'h99, ak); i2c_stop;
    chk("R7 nack while busy", ak, 0);
    chk("R7 no store while busy", ram[8'h12], 8'h3C);
    sw_release;
    chk("R7 busy cleared", busy, 0);
    chk("R8 status cleared", status, 0);
    w(2);
    chk("R9 irq drops", irq, 0);

    // R3 page wrap, 8-byte page
    cfg_page_len = 2'd0;
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hC0 + 8'(k);
    do_write(8'h1E, 4, aa);
    chk("R3 8B wrap 18", ram[8'h18], 8'hC2);
    chk("R3 8B wrap 19", ram[8'h19], 8'hC3);
    chk("R3 8B no spill 20", ram[8'h20], exp_ram[8'h20]);
    chk("R3 ptr in page", cur_addr, 8'h1A);
    sw_release;

    // R3 32-byte page
    cfg_page_len = 2'd2;
    for (int k = 0; k < 3; k++) wbuf[k] = 8'hD0 + 8'(k);
    do_write(8'h3E, 3, aa);
    chk("R3 32B wrap 20", ram[8'h20], 8'hD2);
    chk("R3 32B no spill 40", ram[8'h40], exp_ram[8'h40]);
    sw_release;

    // R1 foreign address
    i2c_start; send_byte({7'h51, 1'b0}, ak);
    chk("R1 foreign nack", ak, 0);
    send_byte(8'h05, ak); send_byte(8'h77, ak); i2c_stop;
    chk("R1 foreign ignored", ram[8'h05], exp_ram[8'h05]);
    chk("R1 no busy", busy, 0);

    // R5 random read via repeated start
    do_rand_read(8'h40, 1);
    chk("R5 random read", rbuf[0], exp_ram[8'h40]);
    chk("R5 dummy write no busy", busy, 0);
    chk("R8 read event", status, 2'b10);
    chk("R4 ptr after read", cur_addr, 8'h41);
    sw_release;

    // R4 current-address read
    i2c_start; send_byte({DEV, 1'b1}, ak); recv_byte(b, 1'b0); i2c_stop;
    chk("R4 current read", b, exp_ram[8'h41]);

    // R5 random read via stop then current read
    i2c_start; send_byte({DEV, 1'b0}, ak); send_byte(8'h80, ak); i2c_stop;
    chk("R5 stop dummy no busy", busy, 0);
    i2c_start; send_byte({DEV, 1'b1}, ak); recv_byte(b, 1'b0); i2c_stop;
    chk("R5 read after stop", b, exp_ram[8'h80]);
    sw_release;

    // R6 sequential rollover, then NACK releases the bus
    i2c_start; send_byte({DEV, 1'b0}, ak); send_byte(8'hFE, ak); i2c_restart;
    send_byte({DEV, 1'b1}, ak);
    for (int k = 0; k < 4; k++) recv_byte(rbuf[k], k != 3);
    recv_byte(b, 1'b0);
    i2c_stop;
    chk("R6 seq FE", rbuf[0], exp_ram[8'hFE]);
    chk("R6 seq FF", rbuf[1], exp_ram[8'hFF]);
    chk("R6 rollover 00", rbuf[2], exp_ram[8'h00]);
    chk("R6 seq 01", rbuf[3], exp_ram[8'h01]);
    chk("R6 released after nack", b, 8'hFF);
    chk("R10 read count", byte_cnt, 4);
    sw_release;

    // random page writes checked by readback
    for (int t = 0; t < 8; t++) begin
      pl = 2'($urandom % 4);
      a  = 8'($urandom % 256);
      n  = 1 + int'($urandom % 6);
      cfg_page_len = pl;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      do_write(a, n, aa);
      chk("R2 random acks", aa, 1);
      chk("R3 random ptr", cur_addr, exp_ptr);
      for (int k = 0; k < n; k++)
        chk("R3 random store", ram[page_addr(a, pl, k)], exp_ram[page_addr(a, pl, k)]);
      sw_release;
      do_rand_read(a, 3);
      for (int k = 0; k < 3; k++)
        chk("R6 random readback", rbuf[k], exp_ram[8'(int'(a) + k)]);
      chk("R4 random read ptr", cur_addr, exp_ptr);
      sw_release;
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule